// File: doc/BRIEF.md
# Power-State Sequencer with Soft Output Ramp

This block decides when an audio output path may run. Reset puts it in an off state, where the outputs are clamped to ground and the sample path is muted. The block stays there until a clock-ratio detector reports that the incoming clocks are usable. It then raises a digital level from zero to mid-scale, which is the common-mode point. The level moves one step for each pacing tick. Only when the level sits at mid-scale does the block open the sample path.

If the detector withdraws its report while the level is rising or while audio is running, the block ramps the level back down to zero and returns to the off state. The ramp level is an output for a downstream analog stage. Samples pass through a gate that outputs zero except in the running state.

Top module: `soft_ramp_seq`

## Requirements
- R1: After reset the state output is 0 (off), the ramp level is 0, the clamp enable is 1, the path enable is 0 and the sample output is 0.
- R2: The state code is 0 off, 1 rising, 2 running, 3 falling. In the off state the block stays off while `clkOk` is low. When `clkOk` is high in the off state, the state is rising one cycle later.
- R3: The clamp enable is high only in the off state. While the clamp enable is high, the ramp level is 0.
- R4: In the rising state with `clkOk` high, every cycle with `stepTick` high raises the ramp level by exactly 1. Cycles without `stepTick` leave the level unchanged.
- R5: When the level reaches mid-scale (128 for the default 8-bit level) in the rising state, the state is running one cycle later. In the running state the level stays at mid-scale whatever `stepTick` does.
- R6: The path enable is high only in the running state. The sample output equals `sampleIn` in the running state and is 0 in every other state.
- R7: When `clkOk` is low in the rising or running state, the state is falling one cycle later. A tick in that same cycle does not change the level.
- R8: In the falling state each `stepTick` lowers the level by 1 until it reaches 0. `clkOk` has no effect in the falling state.
- R9: In the falling state with a level of 0, the state is off one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkOk | input | 1 | Clock-ratio detector reports usable clocks |
| stepTick | input | 1 | One-cycle pacing pulse for the ramp |
| sampleIn | input | SAMPLE_W | Audio sample from the filter path |
| clampEn | output | 1 | Clamp the outputs to ground |
| pathEn | output | 1 | Sample path is released |
| rampLevel | output | LVL_W | Current ramp level |
| pwrState | output | 2 | State code (0 off, 1 rising, 2 running, 3 falling) |
| sampleOut | output | SAMPLE_W | Gated sample, zero unless running |

## Verification
The assertions assume that `stepTick` is a clean synchronous pulse, which may be high on consecutive cycles. They also assume that `clkOk` is already synchronised, so that a change lands on a clock edge. The stimulus changes every input on the falling edge and raises each tick for exactly one cycle. The stimulus sweeps the full rise and the full fall so that every level value is compared against its arithmetic expectation. It also covers:
- a drop of `clkOk` that arrives together with a tick;
- a return of `clkOk` during the fall;
- a drop of `clkOk` while the level is still at zero.

// File: rtl/soft_ramp_pkg.sv
package soft_ramp_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_RISE = 2'd1,
    ST_RUN  = 2'd2,
    ST_FALL = 2'd3
  } pwrState_e;

  // strobes from the control FSM to the ramp/gate datapath
  typedef struct packed {
    logic incr;
    logic decr;
    logic clear;
    logic pass;
  } rampCmd_t;
endpackage

// File: rtl/soft_ramp_ctrl.sv
module soft_ramp_ctrl
  import soft_ramp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      clkOk,
  input  logic      stepTick,
  input  logic      atMid,
  input  logic      atZero,
  output rampCmd_t  cmd,
  output pwrState_e state
);
  pwrState_e nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_OFF:  if (clkOk) nextState = ST_RISE;
      ST_RISE: begin
        if (!clkOk)     nextState = ST_FALL;
        else if (atMid) nextState = ST_RUN;
      end
      ST_RUN:  if (!clkOk) nextState = ST_FALL;
      ST_FALL: if (atZero) nextState = ST_OFF;
      default: nextState = ST_OFF;
    endcase
  end

  always_comb begin
    cmd.incr  = (state == ST_RISE) && clkOk && stepTick && !atMid;
    cmd.decr  = (state == ST_FALL) && stepTick && !atZero;
    cmd.clear = (state == ST_OFF);
    cmd.pass  = (state == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  p_off_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && !clkOk) |=> state == ST_OFF);
  p_wake_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && clkOk) |=> state == ST_RISE);
  p_loss_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_RISE || state == ST_RUN) && !clkOk) |=> state == ST_FALL);
  p_fall_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FALL && atZero) |=> state == ST_OFF);
  p_no_dual_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.incr && cmd.decr));
endmodule

// File: rtl/soft_ramp_dp.sv
module soft_ramp_dp
  import soft_ramp_pkg::*;
#(
  parameter int LVL_W    = 8,
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  rampCmd_t            cmd,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [LVL_W-1:0]    level,
  output logic                atMid,
  output logic                atZero,
  output logic [SAMPLE_W-1:0] sampleOut
);
  localparam logic [LVL_W-1:0] MID_LVL = LVL_W'(1) << (LVL_W - 1);

  always_ff @(posedge clk) begin
    if (!rstN || cmd.clear) level <= '0;
    else if (cmd.incr)      level <= level + LVL_W'(1);
    else if (cmd.decr)      level <= level - LVL_W'(1);
  end

  assign atMid     = (level == MID_LVL);
  assign atZero    = (level == '0);
  assign sampleOut = cmd.pass ? sampleIn : '0;

  p_never_above_mid_r5: assert property (@(posedge clk) disable iff (!rstN)
    level <= MID_LVL);
  p_mute_r6: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.pass |-> sampleOut == '0);
endmodule

// File: rtl/soft_ramp_seq.sv
module soft_ramp_seq
  import soft_ramp_pkg::*;
#(
  parameter int LVL_W    = 8,
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clkOk,
  input  logic                stepTick,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic                clampEn,
  output logic                pathEn,
  output logic [LVL_W-1:0]    rampLevel,
  output logic [1:0]          pwrState,
  output logic [SAMPLE_W-1:0] sampleOut
);
  localparam logic [LVL_W-1:0] MID_LVL = LVL_W'(1) << (LVL_W - 1);

  rampCmd_t  cmd;
  pwrState_e state;
  logic      atMid, atZero;

  soft_ramp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clkOk(clkOk), .stepTick(stepTick),
    .atMid(atMid), .atZero(atZero), .cmd(cmd), .state(state)
  );

  soft_ramp_dp #(.LVL_W(LVL_W), .SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sampleIn(sampleIn),
    .level(rampLevel), .atMid(atMid), .atZero(atZero), .sampleOut(sampleOut)
  );

  assign clampEn  = (state == ST_OFF);
  assign pathEn   = cmd.pass;
  assign pwrState = state;

  p_clamp_level_r3: assert property (@(posedge clk) disable iff (!rstN)
    clampEn |-> rampLevel == '0);
  p_rise_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RISE && clkOk && stepTick && rampLevel != MID_LVL)
      |=> rampLevel == $past(rampLevel) + LVL_W'(1));
  p_run_level_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> rampLevel == MID_LVL);
  p_run_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    pathEn |-> state == ST_RUN);
  p_loss_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_RISE || state == ST_RUN) && !clkOk) |=> $stable(rampLevel));
  p_fall_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FALL && stepTick && rampLevel != '0)
      |=> rampLevel == $past(rampLevel) - LVL_W'(1));
endmodule

// File: tb/soft_ramp_seq_test.sv
`timescale 1ns/1ps
module soft_ramp_seq_test;
  localparam int LVL_W = 8;
  localparam int SW    = 24;
  localparam int MID   = 1 << (LVL_W - 1);

  logic clk = 1'b0;
  logic rstN, clkOk, stepTick;
  logic [SW-1:0] sampleIn, sampleOut;
  logic clampEn, pathEn;
  logic [LVL_W-1:0] rampLevel;
  logic [1:0] pwrState;

  int nChecks = 0;
  int nFail   = 0;

  always #2.5 clk = ~clk;

  soft_ramp_seq #(.LVL_W(LVL_W), .SAMPLE_W(SW)) uut (
    .clk(clk), .rstN(rstN), .clkOk(clkOk), .stepTick(stepTick),
    .sampleIn(sampleIn), .clampEn(clampEn), .pathEn(pathEn),
    .rampLevel(rampLevel), .pwrState(pwrState), .sampleOut(sampleOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tickOnce();
    stepTick = 1'b1;
    @(negedge clk);
    stepTick = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; clkOk = 1'b0; stepTick = 1'b0; sampleIn = 24'hA5A5A5;
    idle(3);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 state", pwrState, 0);
    chk("R1 level", rampLevel, 0);
    chk("R1 clamp", clampEn, 1);
    chk("R1 path", pathEn, 0);
    chk("R6 muted at reset", sampleOut, 0);
    // R2 stays off without clocks
    idle(5);
    chk("R2 hold off", pwrState, 0);
    clkOk = 1'b1;
    idle(1);
    chk("R2 wake", pwrState, 1);
    chk("R3 clamp off in rise", clampEn, 0);
    chk("R6 muted in rise", sampleOut, 0);
    // R4 no tick -> no step
    idle(4);
    chk("R4 no tick", rampLevel, 0);
    // R4 full rise sweep
    for (int k = 1; k <= MID; k++) begin
      tickOnce();
      chk("R4 rise level", rampLevel, k);
      chk("R4 still rising", pwrState, 1);
    end
    idle(1);
    chk("R5 run", pwrState, 2);
    chk("R6 path on", pathEn, 1);
    chk("R6 pass", sampleOut, sampleIn);
    sampleIn = 24'h123456;
    #0.1;
    chk("R6 pass new", sampleOut, 24'h123456);
    for (int k = 0; k < 3; k++) begin
      tickOnce();
      chk("R5 level held", rampLevel, MID);
    end
    // R7 loss in run
    clkOk = 1'b0;
    idle(1);
    chk("R7 fall", pwrState, 3);
    chk("R7 level kept", rampLevel, MID);
    chk("R6 path off", pathEn, 0);
    chk("R6 muted in fall", sampleOut, 0);
    // R8 full fall sweep, clkOk back high is ignored
    clkOk = 1'b1;
    for (int k = MID - 1; k >= 0; k--) begin
      tickOnce();
      chk("R8 fall level", rampLevel, k);
      chk("R8 still falling", pwrState, 3);
    end
    idle(1);
    chk("R9 off", pwrState, 0);
    chk("R3 clamp on", clampEn, 1);
    idle(1);
    chk("R2 rewake", pwrState, 1);
    for (int k = 0; k < 5; k++) tickOnce();
    chk("R4 partial", rampLevel, 5);
    // R7 loss with simultaneous tick
    clkOk = 1'b0;
    tickOnce();
    chk("R7 abort state", pwrState, 3);
    chk("R7 abort level", rampLevel, 5);
    for (int k = 4; k >= 0; k--) begin
      tickOnce();
      chk("R8 short fall", rampLevel, k);
    end
    idle(1);
    chk("R9 off after short fall", pwrState, 0);
    // R7/R9 loss at level zero
    clkOk = 1'b1;
    idle(1);
    chk("R2 wake again", pwrState, 1);
    clkOk = 1'b0;
    idle(1);
    chk("R7 fall at zero", pwrState, 3);
    idle(1);
    chk("R9 off from zero", pwrState, 0);
    // R1 reset mid-ramp
    clkOk = 1'b1;
    idle(1);
    for (int k = 0; k < 10; k++) tickOnce();
    rstN = 1'b0;
    idle(1);
    rstN = 1'b1;
    clkOk = 1'b0;
    chk("R1 reset state mid", pwrState, 0);
    chk("R1 reset level mid", rampLevel, 0);
    chk("R1 reset clamp mid", clampEn, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #1000000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule